// File: doc/BRIEF.md
# Signed Booth-Dadda Multiplier

This block multiplies two signed two's complement operands of `N` bits and returns the exact `2N`-bit signed product. The multiplier operand `b_i` is recoded in radix 4: each overlapping three-bit window picks one multiple of `a_i` from {-2, -1, 0, +1, +2}. That gives `ceil(N/2)` partial-product rows. Negative multiples are formed by bitwise inversion, with a separate +1 bit placed at the row's lowest column. Sign extension is replaced by an inverted top bit in each row plus one precomputed constant row.

The bit heap is reduced column by column with full and half adders. The reduction follows the target-height sequence 2, 3, 4, 6, 9, 13, ... The first stage aims at the largest target below the tallest column, and each later stage aims at the next smaller target until two rows remain. One carry-propagate adder sums those two rows. The whole adder schedule is computed at elaboration from `N`. With `REG_OUT` = 1 (the default) the product is captured in an output register, so it appears one clock after the operands.

Top module: `booth_dadda_mult`

## Requirements
- R1: With `REG_OUT` = 1, `p_o` after each rising clock edge equals the exact signed product of the `a_i` and `b_i` sampled at that edge, as a `2N`-bit two's complement value.
- R2: While `rst_ni` is low, `p_o` is 0 whatever the operands are. Reset takes effect without waiting for a clock edge.
- R3: If either operand is zero, the product is zero.
- R4: The most negative value times itself gives +2^(2N-2), which is 0x40000000 for N = 16.
- R5: When both operands are nonzero, the product's top bit equals the XOR of the operands' top bits.
- R6: `b_i` = 1 gives `a_i` sign-extended to `2N` bits, and `b_i` = -1 gives the `2N`-bit negation of `a_i`.
- R7: The product is exact when the recoded digits of `b_i` are all ±2 (0x6666 alternates -2/+2) or mix ±1 and ±2 (0x9999, 0xAAAA).
- R8: Swapping the operands gives the same product, although the two operands take different paths.
- R9: The extreme operands give exact results: max×max = (2^(N-1)-1)^2 and max×min = -(2^(N-1)-1)·2^(N-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | N | Multiplicand, signed |
| b_i | input | N | Multiplier operand, Booth-recoded, signed |
| p_o | output | 2N | Signed product |

## Verification
Zero, ±1 and power-of-two style multiplier operands each reach a single partial-product row and the negation-bit path. Errors in the +1 placement or in the inverted sign bit therefore show up directly. The operands 0x6666, 0x9999 and 0xAAAA drive every row into the ±2 and ±1 multiples, which tells apart faults in the shift selection from faults in the inversion. The most negative operand squared, together with max×max and max×min, reaches the top column and the sign-extension constant. Swapped-operand pairs and random vectors cover general column heights, where a wrong full/half adder count or a dropped carry corrupts only some products.

// File: rtl/booth_dadda_pkg.sv
package booth_dadda_pkg;

  localparam int MAX_COLS = 128;

  function automatic int pp_rows(input int n);
    return (n + 1) / 2;
  endfunction

  // lowest / highest partial-product row that has a bit in column c
  function automatic int row_lo(input int n, input int c);
    return (c > n) ? (c - n + 1) / 2 : 0;
  endfunction

  function automatic int row_hi(input int n, input int c);
    int k;
    k = c / 2;
    if (k > pp_rows(n) - 1) k = pp_rows(n) - 1;
    return k;
  endfunction

  function automatic int rows_in_col(input int n, input int c);
    int lo, hi;
    lo = row_lo(n, c);
    hi = row_hi(n, c);
    return (hi >= lo) ? hi - lo + 1 : 0;
  endfunction

  function automatic int has_neg(input int n, input int c);
    return ((c % 2) == 0 && (c / 2) < pp_rows(n)) ? 1 : 0;
  endfunction

  // sign-extension constant: minus the sum of 2^(n+2k) over all rows
  function automatic logic [255:0] sext_const(input int n);
    logic [255:0] acc;
    acc = '0;
    for (int k = 0; k < pp_rows(n); k++) acc = acc + (256'(1) << (n + 2 * k));
    return -acc;
  endfunction

  function automatic int has_const(input int n, input int c);
    logic [255:0] v;
    v = sext_const(n);
    return v[c] ? 1 : 0;
  endfunction

  function automatic int dadda_target(input int j);
    int d;
    d = 2;
    for (int i = 1; i < j; i++) d = (d * 3) / 2;
    return d;
  endfunction

  function automatic int n_stages(input int n);
    int hmax, s;
    logic [255:0] v;
    v = sext_const(n);
    hmax = 0;
    for (int c = 0; c < 2 * n; c++)
      if (rows_in_col(n, c) + has_neg(n, c) + int'(v[c]) > hmax)
        hmax = rows_in_col(n, c) + has_neg(n, c) + int'(v[c]);
    s = 0;
    while (dadda_target(s + 1) < hmax) s++;
    return s;
  endfunction

  // what: 0 = column height entering stage s, 1 = full adders, 2 = half adders
  function automatic int sched(input int n, input int s, input int c, input int what);
    int h  [MAX_COLS];
    int hn [MAX_COLS];
    int nst, d, cin, e, fa, ha;
    logic [255:0] v;
    v = sext_const(n);
    nst = n_stages(n);
    for (int i = 0; i < MAX_COLS; i++) begin
      h[i]  = (i < 2 * n) ? rows_in_col(n, i) + has_neg(n, i) + int'(v[i]) : 0;
      hn[i] = 0;
    end
    for (int st = 0; st <= s; st++) begin
      if (st == s && what == 0) return h[c];
      d = dadda_target(nst - st);
      cin = 0;
      for (int i = 0; i < 2 * n; i++) begin
        e  = h[i] + cin - d;
        fa = (e > 0) ? e / 2 : 0;
        ha = (e > 0) ? e % 2 : 0;
        if (st == s && i == c) return (what == 1) ? fa : ha;
        hn[i] = h[i] - 2 * fa - ha + cin;
        cin = fa + ha;
      end
      for (int i = 0; i < MAX_COLS; i++) h[i] = hn[i];
    end
    return 0;
  endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen #(
  parameter int N   = 16,
  parameter int NPP = (N + 1) / 2
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [N:0]     pp_o [NPP],
  output logic [NPP-1:0] neg_o
);
  localparam int EW = 2 * NPP + 1;

  logic [EW-1:0] ext;
  logic [N:0]    a_x1, a_x2;

  assign ext  = EW'($signed({b_i, 1'b0}));
  assign a_x1 = {a_i[N-1], a_i};
  assign a_x2 = {a_i, 1'b0};

  for (genvar k = 0; k < NPP; k++) begin : g_row
    logic [2:0] grp;
    logic       sel1, sel2;
    logic [N:0] mag, val;
    assign grp  = ext[2*k +: 3];
    assign sel1 = grp[0] ^ grp[1];
    assign sel2 = (grp == 3'b011) | (grp == 3'b100);
    assign mag  = sel1 ? a_x1 : (sel2 ? a_x2 : '0);
    assign val  = grp[2] ? ~mag : mag;
    assign pp_o[k]  = {~val[N], val[N-1:0]};
    assign neg_o[k] = grp[2];
  end
endmodule

// File: rtl/dadda_reducer.sv
module dadda_reducer #(
  parameter int N    = 16,
  parameter int PW   = 2 * N,
  parameter int MAXH = (N + 1) / 2 + 2
) (
  input  logic [MAXH-1:0] heap_i [PW],
  output logic [PW-1:0]   row0_o,
  output logic [PW-1:0]   row1_o
);
  import booth_dadda_pkg::*;

  localparam int NS = n_stages(N);

  logic [MAXH-1:0] lvl   [NS+1][PW];
  logic [MAXH-1:0] sum_w [NS+1][PW];
  logic [MAXH-1:0] car_w [NS+1][PW];

  for (genvar c = 0; c < PW; c++) begin : g_in
    assign lvl[0][c] = heap_i[c];
  end

  for (genvar s = 0; s < NS; s++) begin : g_stage
    for (genvar c = 0; c < PW; c++) begin : g_col
      localparam int FA = sched(N, s, c, 1);
      localparam int HA = sched(N, s, c, 2);
      localparam int HI = sched(N, s, c, 0);
      localparam int CI = (c > 0) ? sched(N, s, c - 1, 1) + sched(N, s, c - 1, 2) : 0;
      localparam int NA = FA + HA;
      localparam int P  = HI - 3 * FA - 2 * HA;
      localparam int HO = P + NA + CI;

      for (genvar j = 0; j < MAXH; j++) begin : g_add
        if (j < FA) begin : g_fa
          logic x, y, z;
          assign x = lvl[s][c][3*j];
          assign y = lvl[s][c][3*j+1];
          assign z = lvl[s][c][3*j+2];
          assign sum_w[s][c][j] = x ^ y ^ z;
          assign car_w[s][c][j] = (x & y) | (z & (x ^ y));
        end else if (j < NA) begin : g_ha
          logic x, y;
          assign x = lvl[s][c][3*FA + 2*(j-FA)];
          assign y = lvl[s][c][3*FA + 2*(j-FA) + 1];
          assign sum_w[s][c][j] = x ^ y;
          assign car_w[s][c][j] = x & y;
        end else begin : g_none
          assign sum_w[s][c][j] = 1'b0;
          assign car_w[s][c][j] = 1'b0;
        end
      end

      // next height order: passed bits, own sums, carries from column c-1
      for (genvar r = 0; r < MAXH; r++) begin : g_out
        if (r < P) begin : g_pass
          assign lvl[s+1][c][r] = lvl[s][c][3*FA + 2*HA + r];
        end else if (r < P + NA) begin : g_sum
          assign lvl[s+1][c][r] = sum_w[s][c][r-P];
        end else if (r < HO) begin : g_car
          assign lvl[s+1][c][r] = car_w[s][c-1][r-P-NA];
        end else begin : g_zero
          assign lvl[s+1][c][r] = 1'b0;
        end
      end
    end
  end

  for (genvar c = 0; c < PW; c++) begin : g_tail
    assign sum_w[NS][c] = '0;
    assign car_w[NS][c] = '0;
    assign row0_o[c] = lvl[NS][c][0];
    assign row1_o[c] = lvl[NS][c][1];
  end
endmodule

// File: rtl/final_cpa.sv
module final_cpa #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);
  assign s_o = x_i + y_i;
endmodule

// File: rtl/booth_dadda_mult.sv
module booth_dadda_mult #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    a_i,
  input  logic [N-1:0]    b_i,
  output logic [2*N-1:0]  p_o
);
  import booth_dadda_pkg::*;

  localparam int PW   = 2 * N;
  localparam int NPP  = pp_rows(N);
  localparam int MAXH = NPP + 2;

  logic [N:0]      pp  [NPP];
  logic [NPP-1:0]  neg;
  logic [MAXH-1:0] heap0 [PW];
  logic [PW-1:0]   row0, row1, sum;

  booth_pp_gen #(.N(N), .NPP(NPP)) u_pp (
    .a_i   (a_i),
    .b_i   (b_i),
    .pp_o  (pp),
    .neg_o (neg)
  );

  // column order inside heap: covering rows, negation bit, constant bit
  for (genvar c = 0; c < PW; c++) begin : g_heap
    localparam int LO = row_lo(N, c);
    localparam int NR = rows_in_col(N, c);
    localparam int NG = has_neg(N, c);
    localparam int NC = has_const(N, c);
    for (genvar r = 0; r < MAXH; r++) begin : g_slot
      if (r < NR) begin : g_pp
        assign heap0[c][r] = pp[LO+r][c - 2*(LO+r)];
      end else if (r == NR && NG == 1) begin : g_neg
        assign heap0[c][r] = neg[c/2];
      end else if (r == NR + NG && NC == 1) begin : g_k
        assign heap0[c][r] = 1'b1;
      end else begin : g_zero
        assign heap0[c][r] = 1'b0;
      end
    end
  end

  dadda_reducer #(.N(N), .PW(PW), .MAXH(MAXH)) u_red (
    .heap_i (heap0),
    .row0_o (row0),
    .row1_o (row1)
  );

  final_cpa #(.W(PW)) u_cpa (
    .x_i (row0),
    .y_i (row1),
    .s_o (sum)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) p_o <= '0;
      else         p_o <= sum;
    end
  end else begin : g_comb
    assign p_o = sum;
  end
endmodule

// File: rtl/booth_dadda_mult_chk.sv
module booth_dadda_mult_chk #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [N-1:0]   a_i,
  input logic [N-1:0]   b_i,
  input logic [2*N-1:0] p_o
);
  localparam int PW = 2 * N;
  localparam logic [N-1:0] MIN_V = {1'b1, {(N-1){1'b0}}};
  localparam logic [PW-1:0] MIN_SQ = {2'b01, {(PW-2){1'b0}}};

  if (REG_OUT) begin : g_chk
    logic [PW-1:0] ref_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ref_q <= '0;
      else         ref_q <= PW'($signed(a_i) * $signed(b_i));
    end

    assert_product_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      p_o == ref_q);

    assert_reset_R2: assert property (@(posedge clk_i)
      !rst_ni |=> p_o == '0);

    assert_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i == '0 || b_i == '0) |=> p_o == '0);

    assert_minsq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i == MIN_V && b_i == MIN_V) |=> p_o == MIN_SQ);

    assert_sign_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i != '0 && b_i != '0) |=> p_o[PW-1] == ($past(a_i[N-1]) ^ $past(b_i[N-1])));
  end
endmodule

bind booth_dadda_mult booth_dadda_mult_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .a_i    (a_i),
  .b_i    (b_i),
  .p_o    (p_o)
);

// File: tb/booth_dadda_mult_bench.sv
`timescale 1ns/1ps
module booth_dadda_mult_bench;
  localparam int N  = 16;
  localparam int PW = 2 * N;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  a_i = '0;
  logic [N-1:0]  b_i = '0;
  logic [PW-1:0] p_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #2 clk_i = ~clk_i;

  booth_dadda_mult #(.N(N), .REG_OUT(1'b1)) u_booth_dadda_mult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (a_i),
    .b_i    (b_i),
    .p_o    (p_o)
  );

  function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return PW'(sa * sb);
  endfunction

  task automatic check(input logic [PW-1:0] got, input logic [PW-1:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_vec(input logic [N-1:0] a, input logic [N-1:0] b, input string req);
    @(negedge clk_i);
    a_i = a;
    b_i = b;
    @(negedge clk_i);
    check(p_o, ref_mul(a, b), req);
  endtask

  task automatic t_reset;
    a_i = 16'h1234;
    b_i = 16'h0055;
    repeat (2) @(negedge clk_i);
    check(p_o, '0, "R2 held in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(p_o, ref_mul(16'h1234, 16'h0055), "R1 first product after reset");
    #0.5 rst_ni = 1'b0;
    #0.5 check(p_o, '0, "R2 async clear");
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_zero;
    run_vec(16'h0000, 16'h7abc, "R3 a zero");
    run_vec(16'h8001, 16'h0000, "R3 b zero");
    run_vec(16'h0000, 16'h8000, "R3 zero times min");
  endtask

  task automatic t_minsq;
    run_vec(16'h8000, 16'h8000, "R4 min squared");
    check(p_o, 32'h4000_0000, "R4 min squared literal");
  endtask

  task automatic t_sign;
    run_vec(16'h0003, 16'hfffb, "R5 pos x neg");
    check({31'b0, p_o[PW-1]}, 32'd1, "R5 sign bit set");
    run_vec(16'hfff0, 16'hff00, "R5 neg x neg");
    check({31'b0, p_o[PW-1]}, 32'd0, "R5 sign bit clear");
  endtask

  task automatic t_unit;
    run_vec(16'hbeef, 16'h0001, "R6 times one");
    check(p_o, {{16{1'b1}}, 16'hbeef}, "R6 sign extended");
    run_vec(16'h1234, 16'hffff, "R6 times minus one");
    check(p_o, -32'h0000_1234, "R6 negated");
    run_vec(16'h8000, 16'hffff, "R6 min times minus one");
  endtask

  task automatic t_digits;
    run_vec(16'h7531, 16'h6666, "R7 digits -2/+2");
    run_vec(16'h9abc, 16'h9999, "R7 digits +1/-2");
    run_vec(16'h8000, 16'haaaa, "R7 digits -1");
    run_vec(16'h7fff, 16'h5555, "R7 digits +1");
    run_vec(16'hc3a5, 16'h4000, "R7 power of two");
  endtask

  task automatic t_commute;
    logic [PW-1:0] first;
    run_vec(16'h6666, 16'h8001, "R8 order ab");
    first = p_o;
    run_vec(16'h8001, 16'h6666, "R8 order ba");
    check(p_o, first, "R8 swapped equal");
  endtask

  task automatic t_extremes;
    run_vec(16'h7fff, 16'h7fff, "R9 max x max");
    check(p_o, 32'h3fff_0001, "R9 max squared literal");
    run_vec(16'h7fff, 16'h8000, "R9 max x min");
    check(p_o, 32'hc000_8000, "R9 max x min literal");
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      run_vec(N'($urandom), N'($urandom), "R1 random");
    end
  endtask

  initial begin
    t_reset();
    t_zero();
    t_minsq();
    t_sign();
    t_unit();
    t_digits();
    t_commute();
    t_extremes();
    t_random();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule